// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Block

This block gives a processor register-level control over five general-purpose I/O ports. One narrow port of 8 pins can raise interrupts. Four wide ports of 18 pins each do not. Every port has three registers: one for the data it drives, one that reads the data on its pins, and one that enables its drivers. Pin inputs pass through a two-flop synchronizer. The synchronized values feed the input-data registers and the trigger logic.

Each pin of the narrow port has its own 3-bit trigger mode. A pin can report its level, report the inverse of its level, force its status bit on for software testing, or latch rising, falling or both edges. The per-pin results form a raw status word. That word is ANDed with a mask to give a masked status word, and any bit set in the masked word drives the single interrupt output. Software clears latched edge events by writing ones to an acknowledge register.

The bus is a plain 32-bit register interface. Writes take effect at the clock edge on which `bus_wr` is high. Read data is a combinational function of the address, so a read completes in the same cycle.

Top module: `gpio_pc_top`

## Requirements
- R1: After reset, all output-data, output-enable, trigger-mode and mask registers are zero, all pin outputs and enables are low, and `irq` is low.
- R2: Narrow port registers sit at byte offsets 0 (drive data), 4 (pin data) and 8 (driver enable). Each holds 8 bits, and bits 31:8 read as zero.
- R3: Wide port k (k = 0..3) has its base at 32 + 16k, with drive data at base, pin data at base+4 and driver enable at base+8. Each holds 18 bits. Port k uses bits 18k+17:18k of the packed pin vectors.
- R4: A pin change becomes visible in the pin-data register two clock edges after it is applied, and not after one.
- R5: The trigger-mode register sits at offset 12. Pin n uses bits 3n+2:3n, and bits 31:24 read as zero.
- R6: Mode 1 makes the raw bit equal to the synchronized pin level. Mode 2 makes it equal to the inverted level. An acknowledge cannot clear a bit held by a level mode.
- R7: Mode 3 holds the raw bit at one.
- R8: Modes 5 (rising), 6 (falling) and 7 (either edge) latch a raw bit when the matching edge occurs. The bit stays set until it is acknowledged.
- R9: At offset 20, writing 1 to a bit clears that pin's latched edge status, and writing 0 has no effect. The register reads as zero.
- R10: Modes 0 and 4 hold the raw bit at zero.
- R11: Raw status reads at offset 24. Masked status at offset 28 equals raw status ANDed with the mask register at offset 16.
- R12: `irq` is high exactly when the masked status is nonzero.
- R13: Offsets outside the map read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pa_in | input | 8 | Narrow port pin inputs |
| pa_out | output | 8 | Narrow port drive data |
| pa_oe | output | 8 | Narrow port driver enables |
| pw_in | input | 72 | Wide port pin inputs, 18 bits per port |
| pw_out | output | 72 | Wide port drive data |
| pw_oe | output | 72 | Wide port driver enables |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check that the disabled and forced modes pin the raw bit low or high, that a latched edge persists until acknowledged, and that an acknowledge with no new edge clears it. They also check that the acknowledge and unmapped offsets read zero, that the unused top byte of the mode register reads zero, and that `irq` never rises while the mask is clear. Only the bench scenarios show the rest: which edge or level each mode code responds to, the exact two-edge synchronizer latency, the address of each wide port, that writes of zero to the acknowledge register and writes to unmapped offsets leave state untouched, and that level status survives an acknowledge.

// File: rtl/gpio_pc_pkg.sv
package gpio_pc_pkg;

  typedef enum logic [2:0] {
    TRG_OFF   = 3'd0,
    TRG_HIGH  = 3'd1,
    TRG_LOW   = 3'd2,
    TRG_FORCE = 3'd3,
    TRG_RSV   = 3'd4,
    TRG_RISE  = 3'd5,
    TRG_FALL  = 3'd6,
    TRG_BOTH  = 3'd7
  } trig_mode_e;

  localparam int OFS_CFG    = 12;
  localparam int OFS_MASK   = 16;
  localparam int OFS_ACK    = 20;
  localparam int OFS_RAW    = 24;
  localparam int OFS_MSK_ST = 28;
  localparam int WIDE_BASE  = 32;
  localparam int WIDE_STEP  = 16;

  // Edge-latching modes are the codes with bit 2 set and a nonzero low pair.
  function automatic logic is_edge_mode(input logic [2:0] m);
    return m[2] & (m[1:0] != 2'b00);
  endfunction

  function automatic logic edge_hit(input logic [2:0] m, input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (trig_mode_e'(m))
      TRG_RISE: return rise;
      TRG_FALL: return fall;
      TRG_BOTH: return rise | fall;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic level_view(input logic [2:0] m, input logic cur);
    case (trig_mode_e'(m))
      TRG_HIGH:  return cur;
      TRG_LOW:   return ~cur;
      TRG_FORCE: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  // Independent map check used by the read-side assertion.
  function automatic logic is_mapped(input int a, input int nwide);
    if (a == 0 || a == 4 || a == 8) return 1'b1;
    if (a >= OFS_CFG && a <= OFS_MSK_ST && (a % 4) == 0) return 1'b1;
    for (int k = 0; k < nwide; k++) begin
      if (a == WIDE_BASE + WIDE_STEP*k || a == WIDE_BASE + WIDE_STEP*k + 4 ||
          a == WIDE_BASE + WIDE_STEP*k + 8) return 1'b1;
    end
    return 1'b0;
  endfunction

endpackage

// File: rtl/gpio_pc_sync.sv
module gpio_pc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_pc_bank.sv
module gpio_pc_bank #(
  parameter int W    = 18,
  parameter int BASE = 32,
  parameter int AW   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_sync,
  output logic [W-1:0]  drv_out,
  output logic [W-1:0]  drv_oe,
  output logic [31:0]   rd_val
);
  localparam logic [AW-1:0] A_DOUT = AW'(BASE);
  localparam logic [AW-1:0] A_DIN  = AW'(BASE + 4);
  localparam logic [AW-1:0] A_OE   = AW'(BASE + 8);

  logic [W-1:0] dout_q, oe_q;
  logic hit_dout, hit_din, hit_oe;

  assign hit_dout = (addr == A_DOUT);
  assign hit_din  = (addr == A_DIN);
  assign hit_oe   = (addr == A_OE);

  gpio_pc_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
    end else if (wr) begin
      if (hit_dout) dout_q <= wdata;
      if (hit_oe)   oe_q   <= wdata;
    end
  end

  assign drv_out = dout_q;
  assign drv_oe  = oe_q;

  always_comb begin
    rd_val = '0;
    if (hit_dout)     rd_val[W-1:0] = dout_q;
    else if (hit_din) rd_val[W-1:0] = pin_sync;
    else if (hit_oe)  rd_val[W-1:0] = oe_q;
  end

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_oe) |=> $stable(oe_q)) else $error("oe changed without write"); // R13
endmodule

// File: rtl/gpio_pc_trig.sv
module gpio_pc_trig
  import gpio_pc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       lvl,
  input  logic       ack,
  output logic       raw,
  output logic       ev
);
  logic prev_q, latch_q, edge_sel;

  assign edge_sel = is_edge_mode(mode);
  assign ev       = edge_hit(mode, lvl, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      latch_q <= edge_sel ? (ev | (latch_q & ~ack)) : 1'b0;
    end
  end

  assign raw = edge_sel ? latch_q : level_view(mode, lvl);

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 || mode == 3'd4) |-> !raw) else $error("disabled mode raised status"); // R10
  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> raw) else $error("forced mode not high"); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && mode[1:0] != 2'b00 && raw && !ack) |=> (!$stable(mode) || raw))
    else $error("edge status dropped without ack"); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2] && mode[1:0] != 2'b00 && ack && !ev) |=> (!$stable(mode) || !raw))
    else $error("ack did not clear edge status"); // R9
endmodule

// File: rtl/gpio_pc_top.sv
module gpio_pc_top
  import gpio_pc_pkg::*;
#(
  parameter int NA_W  = 8,
  parameter int WW    = 18,
  parameter int NWIDE = 4,
  parameter int AW    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NA_W-1:0]     pa_in,
  output logic [NA_W-1:0]     pa_out,
  output logic [NA_W-1:0]     pa_oe,
  input  logic [NWIDE*WW-1:0] pw_in,
  output logic [NWIDE*WW-1:0] pw_out,
  output logic [NWIDE*WW-1:0] pw_oe,
  output logic                irq
);
  localparam int CFG_W = 3 * NA_W;

  logic [NA_W-1:0]  pa_sync;
  logic [31:0]      pa_rd;
  logic [31:0]      wide_rd [NWIDE];
  logic [CFG_W-1:0] cfg_q;
  logic [NA_W-1:0]  mask_q;
  logic [NA_W-1:0]  raw_st, masked_st, ack_pulse, pin_ev;
  logic             hit_cfg, hit_mask, hit_ack, hit_raw, hit_msk;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[31:CFG_W];

  assign hit_cfg  = (bus_addr == AW'(OFS_CFG));
  assign hit_mask = (bus_addr == AW'(OFS_MASK));
  assign hit_ack  = (bus_addr == AW'(OFS_ACK));
  assign hit_raw  = (bus_addr == AW'(OFS_RAW));
  assign hit_msk  = (bus_addr == AW'(OFS_MSK_ST));

  gpio_pc_bank #(.W(NA_W), .BASE(0), .AW(AW)) u_bank_a (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata[NA_W-1:0]), .pin_in(pa_in), .pin_sync(pa_sync),
    .drv_out(pa_out), .drv_oe(pa_oe), .rd_val(pa_rd)
  );

  for (genvar k = 0; k < NWIDE; k++) begin : g_wide
    logic [WW-1:0] sync_unused;
    gpio_pc_bank #(.W(WW), .BASE(WIDE_BASE + WIDE_STEP*k), .AW(AW)) u_bank (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr),
      .wdata(bus_wdata[WW-1:0]), .pin_in(pw_in[k*WW +: WW]),
      .pin_sync(sync_unused), .drv_out(pw_out[k*WW +: WW]),
      .drv_oe(pw_oe[k*WW +: WW]), .rd_val(wide_rd[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (hit_cfg)  cfg_q  <= bus_wdata[CFG_W-1:0];
      if (hit_mask) mask_q <= bus_wdata[NA_W-1:0];
    end
  end

  assign ack_pulse = (bus_wr && hit_ack) ? bus_wdata[NA_W-1:0] : '0;

  for (genvar n = 0; n < NA_W; n++) begin : g_pin
    gpio_pc_trig u_trig (
      .clk(clk), .rst_n(rst_n), .mode(cfg_q[3*n +: 3]), .lvl(pa_sync[n]),
      .ack(ack_pulse[n]), .raw(raw_st[n]), .ev(pin_ev[n])
    );
  end

  assign masked_st = raw_st & mask_q;
  assign irq       = |masked_st;

  always_comb begin
    bus_rdata = pa_rd;
    for (int k = 0; k < NWIDE; k++) bus_rdata = bus_rdata | wide_rd[k];
    if (hit_cfg)  bus_rdata[CFG_W-1:0] = cfg_q;
    if (hit_mask) bus_rdata[NA_W-1:0]  = mask_q;
    if (hit_raw)  bus_rdata[NA_W-1:0]  = raw_st;
    if (hit_msk)  bus_rdata[NA_W-1:0]  = masked_st;
  end

  AST_ACK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ack |-> (bus_rdata == 32'd0)) else $error("ack offset read nonzero"); // R9
  AST_CFG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cfg |-> (bus_rdata[31:24] == 8'd0)) else $error("cfg top byte nonzero"); // R5
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mapped(int'(bus_addr), NWIDE) |-> (bus_rdata == 32'd0)) else $error("unmapped read nonzero"); // R13
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0)) else $error("irq with empty mask"); // R12
endmodule

// File: tb/gpio_pc_top_bench.sv
module gpio_pc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pa_in = '0;
  logic [7:0]  pa_out, pa_oe;
  logic [71:0] pw_in = '0;
  logic [71:0] pw_out, pw_oe;
  logic        irq;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  gpio_pc_top u_gpio_pc_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pa_in(pa_in),
    .pa_out(pa_out), .pa_oe(pa_oe), .pw_in(pw_in), .pw_out(pw_out),
    .pw_oe(pw_oe), .irq(irq)
  );

  // {mode[2:0], start level, end level, expected raw, expected raw after ack}
  localparam int NV = 13;
  localparam logic [6:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b1, 1'b1, 1'b1},  // R6 high level
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // R6
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b1},  // R6 low level
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b0},  // R6
    {3'd3, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 forced
    {3'd5, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 rising
    {3'd5, 1'b1, 1'b0, 1'b0, 1'b0},  // R8
    {3'd6, 1'b1, 1'b0, 1'b1, 1'b0},  // R8 falling
    {3'd6, 1'b0, 1'b1, 1'b0, 1'b0},  // R8
    {3'd7, 1'b0, 1'b1, 1'b1, 1'b0},  // R8 both
    {3'd7, 1'b1, 1'b0, 1'b1, 1'b0},  // R8
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b0},  // R10 off
    {3'd4, 1'b0, 1'b1, 1'b0, 1'b0}   // R10 reserved
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 7'(a);
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    chk("R1 pa_out", {24'd0, pa_out}, 32'd0);
    chk("R1 pa_oe", {24'd0, pa_oe}, 32'd0);
    chk("R1 pw_oe", pw_oe[31:0] | pw_oe[71:40], 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(12, r); chk("R1 cfg", r, 32'd0);
    rd(16, r); chk("R1 mask", r, 32'd0);

    // R2 narrow port map
    wr(0, 32'hFFFF_FFA5);
    chk("R2 pa_out", {24'd0, pa_out}, 32'hA5);
    rd(0, r); chk("R2 dout read", r, 32'hA5);
    wr(8, 32'h0000_013C);
    chk("R2 pa_oe", {24'd0, pa_oe}, 32'h3C);
    rd(8, r); chk("R2 oe read", r, 32'h3C);

    // R4 synchronizer latency and R2 input read
    @(negedge clk);
    bus_addr = 7'd4;
    pa_in = 8'h5A;
    @(negedge clk); #1 chk("R4 after one edge", bus_rdata, 32'h00);
    @(negedge clk); #1 chk("R4 after two edges", bus_rdata, 32'h5A);
    pa_in = 8'h00;
    idle(3);

    // R3 wide ports
    wr(48, 32'hFFFE_AAAA);
    chk("R3 port1 out", {14'd0, pw_out[35:18]}, 32'h2AAAA);
    chk("R3 port0 untouched", {14'd0, pw_out[17:0]}, 32'd0);
    wr(56, 32'h0001_5555);
    chk("R3 port1 oe", {14'd0, pw_oe[35:18]}, 32'h15555);
    pw_in[71:54] = 18'h3_0F0F;
    idle(3);
    rd(84, r); chk("R3 port3 din", r, 32'h3_0F0F);
    wr(32, 32'h0000_0123);
    rd(32, r); chk("R3 port0 dout", r, 32'h123);

    // R13 unmapped offsets
    wr(44, 32'hFFFF_FFFF);
    rd(44, r); chk("R13 unmapped read", r, 32'd0);
    rd(40, r); chk("R13 neighbour oe kept", r, 32'd0);
    rd(96, r); chk("R13 beyond map", r, 32'd0);

    // R5 field packing: pin 7 in bits 23:21
    wr(12, 32'hFFE0_0000);
    rd(12, r); chk("R5 cfg pin7 field", r, 32'h00E0_0000);
    wr(12, 32'd0);

    // Table walk on pin 0
    for (int i = 0; i < NV; i++) begin
      logic [6:0] v;
      v = VEC[i];
      wr(12, 32'd0);
      pa_in[0] = v[3];
      idle(4);
      wr(12, {29'd0, v[6:4]});
      idle(2);
      pa_in[0] = v[2];
      idle(4);
      rd(24, r); chk($sformatf("R6/R7/R8/R10 raw mode %0d", v[6:4]), {31'd0, r[0]}, {31'd0, v[1]});
      wr(20, 32'h1);
      rd(24, r); chk($sformatf("R9 raw after ack mode %0d", v[6:4]), {31'd0, r[0]}, {31'd0, v[0]});
    end

    // R9 ack of zero keeps latched edge, ack reads zero; R11, R12 masking
    wr(12, 32'd0);
    pa_in = 8'h00;
    idle(4);
    wr(12, {3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd5});
    idle(2);
    pa_in = 8'h81;
    idle(4);
    wr(20, 32'h0);
    rd(24, r); chk("R9 zero ack no effect", r, 32'h81);
    rd(20, r); chk("R9 ack reads zero", r, 32'd0);
    chk("R12 irq low, mask clear", {31'd0, irq}, 32'd0);
    wr(16, 32'h01);
    rd(28, r); chk("R11 masked status", r, 32'h01);
    chk("R12 irq high", {31'd0, irq}, 32'd1);
    wr(20, 32'h01);
    rd(28, r); chk("R11 masked after ack", r, 32'h00);
    rd(24, r); chk("R11 raw after ack", r, 32'h80);
    chk("R12 irq low after ack", {31'd0, irq}, 32'd0);
    wr(16, 32'h80);
    chk("R12 irq via pin7", {31'd0, irq}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule